// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This controller guards a battery-backed memory while its supply comes and goes. Two comparator flags arrive from outside. One says the supply is under the deselect level. The other says it is under the lower battery switchover level. Each flag is synchronised and debounced inside the block. From the two cleaned flags a five-state sequencer drives three signals: a deselect/write-protect signal for the memory, a battery-connect signal and an output high-impedance signal.

When a dip is confirmed, an idle memory is protected at once. A memory reporting an access in flight gets a grace window to finish. That window is bounded, so protection arrives no later than a fixed number of cycles after the dip. When the supply falls further, the battery is connected. When the supply climbs back above both levels, protection stays on for a long recovery interval so that the host processor can settle. A new dip during that interval sends the block back to protection. The interval then starts again from zero. Reset puts the block in the protected condition with the battery connected.

Top module: `pfsTop`

## Requirements
- R1: While reset is held, and in the cycle after reset is released, protectOut, outputsHiZ and batteryOn are all 1.
- R2: Each raw flag passes two synchroniser flops and then a debounce stage. A raw level held for fewer than DEBOUNCE_CYCLES cycles at the synchroniser output has no effect on any output. A raw pulse of DEBOUNCE_CYCLES-1 cycles is therefore ignored.
- R3: Take the block in normal operation with accessBusy low. If deselRaw goes to 1 (1 = supply below the deselect level) and stays there, protectOut and outputsHiZ rise on the (DEBOUNCE_CYCLES+3)-th rising edge after the change.
- R4: If accessBusy is 1 when the dip is confirmed, protectOut stays 0 while the access runs. It rises on the first edge at which accessBusy is seen at 0.
- R5: If accessBusy stays 1, protectOut still rises exactly GRACE_CYCLES edges after the grace window opened. That is edge DEBOUNCE_CYCLES+3+GRACE_CYCLES after the raw change.
- R6: outputsHiZ equals protectOut in every cycle. While the block is protected, accessBusy has no effect on any output.
- R7: When switchRaw goes to 1 (1 = supply below the switchover level) while the block is protected, batteryOn rises one edge after the flag is confirmed. It falls one edge after switchRaw is confirmed back at 0. batteryOn is only ever 1 while protectOut is 1.
- R8: Once both flags are confirmed at 0, protectOut stays 1 for RECOVERY_CYCLES further edges. It falls on edge DEBOUNCE_CYCLES+3+RECOVERY_CYCLES after the raw change.
- R9: A confirmed dip during recovery keeps protectOut at 1. After the supply returns again, the full RECOVERY_CYCLES interval is counted afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| deselRaw | input | 1 | Raw flag, 1 = supply below deselect level |
| switchRaw | input | 1 | Raw flag, 1 = supply below battery switchover level |
| accessBusy | input | 1 | 1 while a memory access is in progress |
| protectOut | output | 1 | 1 = memory deselected and write-protected |
| outputsHiZ | output | 1 | 1 = memory outputs forced to high impedance |
| batteryOn | output | 1 | 1 = battery connected to the memory |

## Verification
The bench builds the block with DEBOUNCE_CYCLES=3, GRACE_CYCLES=20 and RECOVERY_CYCLES=50, in place of the multi-thousand and multi-million cycle defaults. This puts the grace timeout and the full recovery interval a few dozen cycles away. Every edge at which the outputs should change can then be checked exactly, on both sides. The short debounce makes a two-cycle glitch a genuine sub-threshold pulse. It also keeps a dip in the middle of recovery short enough to show the restart against the interval that would otherwise have expired.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_GRACE,
    ST_PROTECT,
    ST_BATTERY,
    ST_RECOVER
  } pfsState_e;

  // control -> datapath
  typedef struct packed {
    logic timerClr;
    logic timerRun;
  } pfsStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic deselLow;
    logic switchLow;
    logic graceDone;
    logic recoverDone;
  } pfsStatus_t;

endpackage

// File: rtl/pfsDatapath.sv
module pfsDatapath
  import pfs_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int GRACE_CYCLES    = 2000,
  parameter int RECOVERY_CYCLES = 2000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rawFlags,   // [0] deselect, [1] switchover
  input  pfsStrobe_t strobe,
  output pfsStatus_t status
);

  localparam int NUM_FLAGS = 2;
  localparam int DB_W      = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam int TIMER_MAX = (GRACE_CYCLES > RECOVERY_CYCLES) ? GRACE_CYCLES : RECOVERY_CYCLES;
  localparam int TM_W      = $clog2(TIMER_MAX + 1);

  logic [NUM_FLAGS-1:0] fltVec;

  // Synchroniser plus debounce, one per flag. Reset assumes the supply is low.
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    logic [1:0]      syncQ;
    logic            fltQ;
    logic [DB_W-1:0] dbCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 2'b11;
        fltQ  <= 1'b1;
        dbCnt <= '0;
      end else begin
        syncQ <= {syncQ[0], rawFlags[g]};
        if (syncQ[1] == fltQ) begin
          dbCnt <= '0;
        end else if (dbCnt == DB_W'(DEBOUNCE_CYCLES - 1)) begin
          fltQ  <= syncQ[1];
          dbCnt <= '0;
        end else begin
          dbCnt <= dbCnt + 1'b1;
        end
      end
    end

    assign fltVec[g] = fltQ;
  end

  // One shared interval timer for the grace window and the recovery hold.
  logic [TM_W-1:0] timerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (strobe.timerClr) begin
      timerQ <= '0;
    end else if (strobe.timerRun && (timerQ != TM_W'(TIMER_MAX))) begin
      timerQ <= timerQ + 1'b1;
    end
  end

  assign status.deselLow    = fltVec[0];
  assign status.switchLow   = fltVec[1];
  assign status.graceDone   = (timerQ == TM_W'(GRACE_CYCLES - 1));
  assign status.recoverDone = (timerQ == TM_W'(RECOVERY_CYCLES - 1));

endmodule

// File: rtl/pfsControl.sv
module pfsControl
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accessBusy,
  input  pfsStatus_t status,
  output pfsStrobe_t strobe,
  output logic       protectOut,
  output logic       outputsHiZ,
  output logic       batteryOn
);

  pfsState_e stateQ, stateNext;
  logic      supplyLow;
  logic      protNext;

  assign supplyLow = status.deselLow | status.switchLow;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_NORMAL:  if (supplyLow) stateNext = accessBusy ? ST_GRACE : ST_PROTECT;
      ST_GRACE:   if (!accessBusy || status.graceDone || status.switchLow) stateNext = ST_PROTECT;
      ST_PROTECT: begin
        if (status.switchLow)     stateNext = ST_BATTERY;
        else if (!status.deselLow) stateNext = ST_RECOVER;
      end
      ST_BATTERY: if (!status.switchLow) stateNext = ST_PROTECT;
      ST_RECOVER: begin
        if (supplyLow)               stateNext = ST_PROTECT;
        else if (status.recoverDone) stateNext = ST_NORMAL;
      end
      default:    stateNext = ST_PROTECT;
    endcase
  end

  assign strobe.timerClr = (stateNext != stateQ);
  assign strobe.timerRun = (stateQ == ST_GRACE) || (stateQ == ST_RECOVER);
  assign protNext        = !((stateNext == ST_NORMAL) || (stateNext == ST_GRACE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_PROTECT;
      protectOut <= 1'b1;
      outputsHiZ <= 1'b1;
      batteryOn  <= 1'b1;
    end else begin
      stateQ     <= stateNext;
      protectOut <= protNext;
      outputsHiZ <= protNext;
      batteryOn  <= (stateNext == ST_BATTERY);
    end
  end

endmodule

// File: rtl/pfsTop.sv
module pfsTop
  import pfs_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int GRACE_CYCLES    = 2000,
  parameter int RECOVERY_CYCLES = 2000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic deselRaw,
  input  logic switchRaw,
  input  logic accessBusy,
  output logic protectOut,
  output logic outputsHiZ,
  output logic batteryOn
);

  pfsStrobe_t strobe;
  pfsStatus_t status;

  pfsDatapath #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .GRACE_CYCLES   (GRACE_CYCLES),
    .RECOVERY_CYCLES(RECOVERY_CYCLES)
  ) i_pfsDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .rawFlags({switchRaw, deselRaw}),
    .strobe  (strobe),
    .status  (status)
  );

  pfsControl i_pfsControl (
    .clk       (clk),
    .rstN      (rstN),
    .accessBusy(accessBusy),
    .status    (status),
    .strobe    (strobe),
    .protectOut(protectOut),
    .outputsHiZ(outputsHiZ),
    .batteryOn (batteryOn)
  );

endmodule

// File: rtl/pfsChecker.sv
module pfsChecker #(
  parameter int GRACE_CYCLES    = 2000,
  parameter int RECOVERY_CYCLES = 2000000
) (
  input logic clk,
  input logic rstN,
  input logic accessBusy,
  input logic protectOut,
  input logic outputsHiZ,
  input logic batteryOn,
  input logic deselLow,
  input logic switchLow
);

  localparam int GC_W = $clog2(GRACE_CYCLES + 3);
  localparam int QC_W = $clog2(RECOVERY_CYCLES + 3);

  logic [GC_W-1:0] graceCnt;   // cycles with a confirmed dip and no protection
  logic [QC_W-1:0] quietCnt;   // cycles with both flags clear

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      graceCnt <= '0;
      quietCnt <= '0;
    end else begin
      if ((deselLow || switchLow) && !protectOut) begin
        if (graceCnt != GC_W'(GRACE_CYCLES + 2)) graceCnt <= graceCnt + 1'b1;
      end else begin
        graceCnt <= '0;
      end
      if (!deselLow && !switchLow) begin
        if (quietCnt != QC_W'(RECOVERY_CYCLES + 1)) quietCnt <= quietCnt + 1'b1;
      end else begin
        quietCnt <= '0;
      end
    end
  end

  AST_DIP_IDLE_PROTECTS: assert property (@(posedge clk) disable iff (!rstN)
    (deselLow && !accessBusy && !protectOut) |=> protectOut);  // R3

  AST_GRACE_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (int'(graceCnt) <= GRACE_CYCLES + 1));  // R5

  AST_HIZ_MATCHES_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    (outputsHiZ == protectOut));  // R6

  AST_BATTERY_ONLY_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    batteryOn |-> protectOut);  // R7

  AST_BATTERY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(switchLow) |=> !batteryOn);  // R7

  AST_RECOVERY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protectOut) |-> (int'(quietCnt) >= RECOVERY_CYCLES));  // R8

endmodule

bind pfsTop pfsChecker #(
  .GRACE_CYCLES   (GRACE_CYCLES),
  .RECOVERY_CYCLES(RECOVERY_CYCLES)
) u_pfsChecker (
  .clk       (clk),
  .rstN      (rstN),
  .accessBusy(accessBusy),
  .protectOut(protectOut),
  .outputsHiZ(outputsHiZ),
  .batteryOn (batteryOn),
  .deselLow  (status.deselLow),
  .switchLow (status.switchLow)
);

// File: tb/test_pfsTop.sv
module test_pfsTop;

  localparam int DB  = 3;
  localparam int GR  = 20;
  localparam int RC  = 50;
  localparam int LAT = DB + 3;   // raw change to output edge

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic deselRaw = 1'b1;
  logic switchRaw = 1'b1;
  logic accessBusy = 1'b0;
  logic protectOut, outputsHiZ, batteryOn;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int    when;
    bit    prot;
    bit    batt;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pfsTop #(
    .DEBOUNCE_CYCLES(DB),
    .GRACE_CYCLES   (GR),
    .RECOVERY_CYCLES(RC)
  ) i_pfsTop (
    .clk       (clk),
    .rstN      (rstN),
    .deselRaw  (deselRaw),
    .switchRaw (switchRaw),
    .accessBusy(accessBusy),
    .protectOut(protectOut),
    .outputsHiZ(outputsHiZ),
    .batteryOn (batteryOn)
  );

  // Monitor: pop expected items at their cycle and compare.
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].when <= cyc) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (protectOut !== e.prot || outputsHiZ !== e.prot || batteryOn !== e.batt) begin
        errors++;
        $display("FAIL %s cyc=%0d: prot=%b hiz=%b batt=%b, expected prot=%b hiz=%b batt=%b",
                 e.tag, cyc, protectOut, outputsHiZ, batteryOn, e.prot, e.prot, e.batt);
      end
    end
  end

  task automatic expectAt(int when, bit prot, bit batt, string tag);
    expItem_t e;
    e.when = when; e.prot = prot; e.batt = batt; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic waitCyc(int when);
    while (cyc < when) @(negedge clk);
  endtask

  task automatic restoreSupply(string tag);
    int n;
    n = cyc;
    deselRaw = 1'b0;
    expectAt(n + LAT - 1 + RC, 1'b1, 1'b0, tag);
    expectAt(n + LAT + RC, 1'b0, 1'b0, tag);
    waitCyc(n + LAT + RC + 2);
  endtask

  initial begin
    int n, m, p, q;
    @(negedge clk);
    expectAt(cyc + 1, 1'b1, 1'b1, "R1 in reset");
    waitCyc(cyc + 3);
    rstN = 1'b1;
    expectAt(cyc + 1, 1'b1, 1'b1, "R1 after release");
    waitCyc(cyc + 4);

    // R7: leave battery after switchover flag clears
    n = cyc; switchRaw = 1'b0;
    expectAt(n + LAT - 1, 1'b1, 1'b1, "R7 battery held");
    expectAt(n + LAT,     1'b1, 1'b0, "R7 battery released");
    waitCyc(n + LAT + 4);

    // R8: first power-up recovery
    n = cyc; deselRaw = 1'b0;
    expectAt(n + LAT,          1'b1, 1'b0, "R8 recovery entered");
    expectAt(n + LAT - 1 + RC, 1'b1, 1'b0, "R8 still held");
    expectAt(n + LAT + RC,     1'b0, 1'b0, "R8 released");
    waitCyc(n + LAT + RC + 2);

    // R3: idle dip protects at once
    n = cyc; deselRaw = 1'b1;
    expectAt(n + LAT - 1, 1'b0, 1'b0, "R3 before");
    expectAt(n + LAT,     1'b1, 1'b0, "R3 protected");
    waitCyc(n + LAT + 2);
    // R6: accessBusy while protected has no effect
    accessBusy = 1'b1;
    expectAt(cyc + 3, 1'b1, 1'b0, "R6 busy ignored");
    waitCyc(cyc + 4);
    accessBusy = 1'b0;
    expectAt(cyc + 2, 1'b1, 1'b0, "R6 busy drop ignored");
    waitCyc(cyc + 3);
    restoreSupply("R8 after R3");

    // R2: two-cycle glitch is rejected
    n = cyc; deselRaw = 1'b1;
    waitCyc(n + DB - 1);
    deselRaw = 1'b0;
    expectAt(n + LAT,      1'b0, 1'b0, "R2 glitch");
    expectAt(n + LAT + 10, 1'b0, 1'b0, "R2 glitch late");
    waitCyc(n + LAT + 12);

    // R4: access completes inside the grace window
    n = cyc; accessBusy = 1'b1; deselRaw = 1'b1;
    expectAt(n + LAT,     1'b0, 1'b0, "R4 grace open");
    expectAt(n + LAT + 4, 1'b0, 1'b0, "R4 grace hold");
    waitCyc(n + LAT + 5);
    accessBusy = 1'b0;
    expectAt(cyc + 1, 1'b1, 1'b0, "R4 protect after access");
    waitCyc(cyc + 3);
    restoreSupply("R8 after R4");

    // R5: grace window times out
    n = cyc; accessBusy = 1'b1; deselRaw = 1'b1;
    expectAt(n + LAT - 1 + GR, 1'b0, 1'b0, "R5 last grace cycle");
    expectAt(n + LAT + GR,     1'b1, 1'b0, "R5 forced");
    waitCyc(n + LAT + GR + 2);
    accessBusy = 1'b0;
    restoreSupply("R8 after R5");

    // R9: dip during recovery restarts the interval
    n = cyc; deselRaw = 1'b1;
    expectAt(n + LAT, 1'b1, 1'b0, "R9 dip");
    waitCyc(n + LAT + 2);
    m = cyc; deselRaw = 1'b0;
    waitCyc(m + LAT + 20);
    p = cyc; deselRaw = 1'b1;
    expectAt(m + LAT + RC + 1, 1'b1, 1'b0, "R9 old interval void");
    waitCyc(p + LAT + 4);
    q = cyc; deselRaw = 1'b0;
    expectAt(q + LAT - 1 + RC, 1'b1, 1'b0, "R9 full restart");
    expectAt(q + LAT + RC,     1'b0, 1'b0, "R9 released");
    waitCyc(q + LAT + RC + 2);

    // R7: both flags from normal, battery one edge after protection
    n = cyc; deselRaw = 1'b1; switchRaw = 1'b1;
    expectAt(n + LAT,     1'b1, 1'b0, "R7 protect first");
    expectAt(n + LAT + 1, 1'b1, 1'b1, "R7 battery on");
    waitCyc(n + LAT + 4);
    m = cyc; switchRaw = 1'b0;
    expectAt(m + LAT - 1, 1'b1, 1'b1, "R7 battery kept");
    expectAt(m + LAT,     1'b1, 1'b0, "R7 battery off");
    waitCyc(m + LAT + 2);
    restoreSupply("R8 final");

    waitCyc(cyc + 2);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule